// File: doc/BRIEF.md
# Programmable PWM Ramp Sequencer

This block drives several PWM outputs whose duty level is set by a tiny per-channel program instead of a fixed compare register. Each channel owns a store of 16-bit instructions and a ramp engine. The engine runs the program to set an 8-bit ramp level. It can set the level at once, move it up or down one count per timed step, or go back to the first instruction. A shared free-running 8-bit counter is compared against each channel's ramp level. The output is high while the level is at or above the counter.

Software loads a program only while the channel is stopped. It writes each instruction as two bytes into that channel's write port, most significant byte first. It then starts the channel by setting that channel's bit in a shared control register. Clearing the bit stops the channel and forces its output low. It also rewinds both the load pointer and the program counter, so the next load and the next run begin at instruction 0.

The engine is a four-state machine. S_IDLE is entered from any state when the channel is disabled. S_IDLE goes to S_FETCH when the enable bit is set. S_FETCH always goes to S_EXEC, latching the instruction at the program counter. S_EXEC returns to S_FETCH after a restart or branch (counter back to 0), after a load, or after a ramp of zero steps. A ramp with one or more steps goes from S_EXEC to S_RAMP. S_RAMP returns to S_FETCH once its final step has been taken.

Top module: `pwm_ramp_seq`

## Requirements
- R1: The counter advances once every CNT_DIV clocks and wraps from 255 to 0. A channel output is high exactly when the channel is enabled and its ramp level is greater than or equal to the counter. Over one full 256-count period an enabled channel therefore stays high for (level + 1) counts.
- R2: Each `prog_we[i]` strobe delivers one byte of `prog_wdata` to channel i. The first byte of a pair becomes bits 15:8 and the second becomes bits 7:0 of the instruction at the load pointer. The pointer advances by one after every completed pair.
- R3: `ctrl_we` loads `ctrl_wdata` into the enable register, where bit i enables channel i. A disabled channel's output is low.
- R4: When LOAD_VARIANT is 1, an instruction with bits 15:14 = 01 copies bits 7:0 into the ramp level and moves on to the next instruction.
- R5: A ramp instruction moves the level by one count per step. Bit 7 selects the direction (0 up, 1 down) and bits 6:0 give the step count. Bits 12:8 give the step time in ticks, where 0 counts as 1. A tick lasts STEP_DIV clocks.
- R6: Ramp steps saturate at 0x00 and 0xFF instead of wrapping.
- R7: The program counter moves past a ramp instruction only after all of its steps have been taken.
- R8: The all-zero word and any word with bits 15 and 13 both set return execution to instruction 0.
- R9: When LOAD_VARIANT is 0, bits 15:14 = 01 do not load. Bit 14 of a ramp instruction instead multiplies the tick by 512.
- R10: Program-port writes to an enabled channel are ignored. Disabling a channel resets its load pointer, byte phase and program counter to 0.
- R11: After reset all outputs are low, all enable bits are clear, every ramp level is 0 and every stored word is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the enable register |
| ctrl_wdata | input | NUM_CH | New enable bits, bit i for channel i |
| prog_we | input | NUM_CH | Per-channel program byte write strobe |
| prog_wdata | input | 8 | Program byte, high byte of a pair first |
| pwm_out | output | NUM_CH | PWM outputs |

## Verification
The enable register takes one edge and the engine one more. A load instruction is therefore reflected in the level about five clocks after the control write, and the bench waits at least 20 clocks before it samples. Duty is measured by counting high samples over exactly 256 counter steps (CNT_DIV = 1), which gives level + 1 whatever the counter phase. For ramps, each step lands a whole tick period (496 clocks with a step time of 31 and STEP_DIV = 16) after the step before it. Each measurement window is placed at least 100 clocks clear of any step edge, so the level is flat for the whole window.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_EXEC  = 2'd2,
        S_RAMP  = 2'd3
    } seq_state_t;

    localparam int unsigned INSTR_W = 16;
    localparam int unsigned LEVEL_W = 8;
    localparam int unsigned SLOW_SHIFT = 9;
endpackage

// File: rtl/pwm_ramp_counter.sv
module pwm_ramp_counter #(
    parameter int unsigned CNT_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] cnt
);
    localparam int unsigned DW = (CNT_DIV > 1) ? $clog2(CNT_DIV) : 1;

    logic [DW-1:0] div_q;
    logic          tick;

    assign tick = (div_q == DW'(CNT_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (tick) begin
            div_q <= '0;
            cnt   <= cnt + 8'd1;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    // R1: counter advances by exactly one per tick
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == $past(cnt) + 8'd1);
endmodule

// File: rtl/ramp_prog_store.sv
module ramp_prog_store #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);
    logic [15:0]   mem [DEPTH];
    logic [AW-1:0] wptr;
    logic          phase;
    logic [7:0]    hi_q;
    logic          en_q;

    assign rdata = mem[raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            phase <= 1'b0;
            hi_q  <= '0;
            en_q  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            en_q <= en;
            if (en_q && !en) begin
                wptr  <= '0;
                phase <= 1'b0;
            end else if (we && !en) begin
                if (!phase) begin
                    hi_q  <= wdata;
                    phase <= 1'b1;
                end else begin
                    mem[wptr] <= {hi_q, wdata};
                    wptr      <= wptr + AW'(1);
                    phase     <= 1'b0;
                end
            end
        end
    end

    // R10: no load progress while running
    a_r10_locked_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en && en_q) |=> ($stable(wptr) && $stable(phase)));
    // R10: falling enable rewinds the load pointer
    a_r10_rewind_on_off: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !en) |=> (wptr == '0 && !phase));
endmodule

// File: rtl/ramp_engine.sv
module ramp_engine
    import pwm_ramp_pkg::*;
#(
    parameter bit          LOAD_VARIANT = 1'b1,
    parameter int unsigned STEP_DIV     = 16384,
    parameter int unsigned AW           = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [AW-1:0] pc,
    input  logic [15:0]   instr,
    output logic [7:0]    level
);
    seq_state_t state, state_nx;

    logic [15:0] ir;
    logic [6:0]  steps_left;
    logic        dir_down;
    logic [31:0] div_q;
    logic [31:0] lim_q;
    logic [31:0] lim_c;
    logic [4:0]  st_c;
    logic        is_jump, is_load, step;

    assign is_jump = (ir == 16'h0000) || (ir[15] && ir[13]);
    assign is_load = LOAD_VARIANT && (ir[15:14] == 2'b01);
    assign step    = (state == S_RAMP) && (div_q == lim_q - 32'd1);

    always_comb begin
        st_c  = (ir[12:8] == 5'd0) ? 5'd1 : ir[12:8];
        lim_c = 32'(STEP_DIV) * 32'(st_c);
        if (!LOAD_VARIANT && ir[14]) lim_c = lim_c << SLOW_SHIFT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  state_nx = S_FETCH;
            S_FETCH: state_nx = S_EXEC;
            S_EXEC: begin
                if (is_jump || is_load || ir[6:0] == 7'd0) state_nx = S_FETCH;
                else                                      state_nx = S_RAMP;
            end
            S_RAMP:  if (step && steps_left == 7'd1) state_nx = S_FETCH;
        endcase
        if (!en) state_nx = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc         <= '0;
            ir         <= '0;
            level      <= '0;
            steps_left <= '0;
            dir_down   <= 1'b0;
            div_q      <= '0;
            lim_q      <= 32'd1;
        end else if (!en) begin
            pc    <= '0;
            div_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_FETCH: ir <= instr;
                S_EXEC: begin
                    if (is_jump) begin
                        pc <= '0;
                    end else if (is_load) begin
                        level <= ir[7:0];
                        pc    <= pc + AW'(1);
                    end else begin
                        dir_down   <= ir[7];
                        steps_left <= ir[6:0];
                        lim_q      <= lim_c;
                        div_q      <= '0;
                        if (ir[6:0] == 7'd0) pc <= pc + AW'(1);
                    end
                end
                S_RAMP: begin
                    if (step) begin
                        div_q      <= '0;
                        steps_left <= steps_left - 7'd1;
                        if (dir_down && level != 8'h00)      level <= level - 8'd1;
                        else if (!dir_down && level != 8'hFF) level <= level + 8'd1;
                        if (steps_left == 7'd1) pc <= pc + AW'(1);
                    end else begin
                        div_q <= div_q + 32'd1;
                    end
                end
            endcase
        end
    end

    // R3: a cleared enable parks the engine
    a_r3_park_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == S_IDLE);
    // R5: while ramping the level moves by at most one count per clock
    a_r5_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RAMP && en) |=> (level == $past(level) ||
            level == $past(level) + 8'd1 || level == $past(level) - 8'd1));
    // R6: saturation at both ends
    a_r6_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (step && en && !dir_down && level == 8'hFF) |=> level == 8'hFF);
    a_r6_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (step && en && dir_down && level == 8'h00) |=> level == 8'h00);
    // R7: no fetch advance before the final step
    a_r7_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RAMP && en && !(step && steps_left == 7'd1)) |=> $stable(pc));
endmodule

// File: rtl/pwm_ramp_seq.sv
module pwm_ramp_seq #(
    parameter int unsigned NUM_CH       = 3,
    parameter int unsigned DEPTH        = 64,
    parameter int unsigned CNT_DIV      = 4,
    parameter int unsigned STEP_DIV     = 16384,
    parameter bit          LOAD_VARIANT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [NUM_CH-1:0] ctrl_wdata,
    input  logic [NUM_CH-1:0] prog_we,
    input  logic [7:0]        prog_wdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [NUM_CH-1:0] en_q;
    logic [7:0]        cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= '0;
        else if (ctrl_we) en_q <= ctrl_wdata;
    end

    pwm_ramp_counter #(.CNT_DIV(CNT_DIV)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [AW-1:0] pc;
        logic [15:0]   instr;
        logic [7:0]    level;

        ramp_prog_store #(.DEPTH(DEPTH)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_q[g]),
            .we    (prog_we[g]),
            .wdata (prog_wdata),
            .raddr (pc),
            .rdata (instr)
        );

        ramp_engine #(
            .LOAD_VARIANT (LOAD_VARIANT),
            .STEP_DIV     (STEP_DIV),
            .AW           (AW)
        ) u_eng (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_q[g]),
            .pc    (pc),
            .instr (instr),
            .level (level)
        );

        assign pwm_out[g] = en_q[g] && (level >= cnt);
    end
endmodule

// File: tb/pwm_ramp_seq_bench.sv
`timescale 1ns/1ps
module pwm_ramp_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [2:0] ctrl_wdata = '0;
    logic [2:0] prog_we = '0;
    logic [7:0] prog_wdata = '0;
    logic [2:0] pwm_out, pwm_alt;
    logic [2:0] ctrl_sh = '0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_ramp_seq #(.CNT_DIV(1), .STEP_DIV(16), .LOAD_VARIANT(1'b1)) u_pwm_ramp_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .prog_we(prog_we), .prog_wdata(prog_wdata), .pwm_out(pwm_out));

    pwm_ramp_seq #(.CNT_DIV(1), .STEP_DIV(16), .LOAD_VARIANT(1'b0)) u_pwm_ramp_seq_alt (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .prog_we(prog_we), .prog_wdata(prog_wdata), .pwm_out(pwm_alt));

    // {channel, word0, word1, word2, expected high count}
    localparam logic [71:0] VEC [6] = '{
        {8'd0, 16'h4000, 16'hA000, 16'h0000, 16'd1},
        {8'd0, 16'h40FF, 16'hA000, 16'h0000, 16'd256},
        {8'd1, 16'h4080, 16'hA000, 16'h0000, 16'd129},
        {8'd2, 16'h4060, 16'hA000, 16'h40F0, 16'd97},
        {8'd2, 16'h4070, 16'h0000, 16'h40F0, 16'd113},
        {8'd1, 16'h4001, 16'h0000, 16'h0000, 16'd2}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [2:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v; ctrl_sh = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic put_word(input int ch, input logic [15:0] w);
        @(negedge clk);
        prog_we = 3'(1 << ch); prog_wdata = w[15:8];
        @(negedge clk);
        prog_wdata = w[7:0];
        @(negedge clk);
        prog_we = '0;
    endtask

    task automatic measure(input int ch, input bit alt, output int n);
        n = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (alt ? pwm_alt[ch] : pwm_out[ch]) n++;
        end
    endtask

    initial begin
        int n, na;
        repeat (4) @(negedge clk);
        chk("R11 outputs low after reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 outputs low out of reset", int'(pwm_out), 0);

        // R9 and R4: same word, two decode variants
        put_word(0, 16'h4105);
        put_word(0, 16'hA000);
        set_ctrl(3'b001);
        repeat (20) @(negedge clk);
        measure(0, 1'b0, n);
        measure(0, 1'b1, na);
        chk("R4 load variant level 5", n, 6);
        chk("R9 prescale variant still at 0", na, 1);
        set_ctrl(3'b000);

        // R1 R2 R4 R8: table walk
        for (int k = 0; k < 6; k++) begin
            int ch;
            ch = int'(VEC[k][71:64]);
            put_word(ch, VEC[k][63:48]);
            put_word(ch, VEC[k][47:32]);
            put_word(ch, VEC[k][31:16]);
            set_ctrl(3'(1 << ch));
            repeat (20) @(negedge clk);
            measure(ch, 1'b0, n);
            chk($sformatf("R1 R2 R8 vector %0d", k), n, int'(VEC[k][15:0]));
            set_ctrl(3'b000);
            measure(ch, 1'b0, n);
            chk($sformatf("R3 disabled output low %0d", k), n, 0);
        end

        // R5 R7: timed ramp up by three, then next ramp
        put_word(0, 16'h4020);
        put_word(0, 16'h1F03);
        put_word(0, 16'h1F7F);
        put_word(0, 16'hA000);
        set_ctrl(3'b001);
        repeat (600) @(negedge clk);
        measure(0, 1'b0, n);
        chk("R5 one step taken", n, 34);
        repeat (744) @(negedge clk);
        measure(0, 1'b0, n);
        chk("R5 three steps taken", n, 36);
        repeat (244) @(negedge clk);
        measure(0, 1'b0, n);
        chk("R7 next ramp begun after last step", n, 37);
        set_ctrl(3'b000);

        // R6: saturation both ways, channels 1 and 2 together
        put_word(1, 16'h40FA); put_word(1, 16'h1F0A);
        put_word(1, 16'h1F7F); put_word(1, 16'hA000);
        put_word(2, 16'h4005); put_word(2, 16'h1F8A);
        put_word(2, 16'h1FFF); put_word(2, 16'hA000);
        set_ctrl(3'b110);
        repeat (6000) @(negedge clk);
        measure(1, 1'b0, n);
        chk("R6 saturate at top", n, 256);
        measure(2, 1'b0, n);
        chk("R6 saturate at bottom", n, 1);
        set_ctrl(3'b000);

        // R10: writes while enabled are dropped
        put_word(1, 16'h4040); put_word(1, 16'hA000);
        set_ctrl(3'b010);
        repeat (20) @(negedge clk);
        put_word(1, 16'h4080);
        repeat (20) @(negedge clk);
        measure(1, 1'b0, n);
        chk("R10 running program unchanged", n, 65);
        set_ctrl(3'b000);
        set_ctrl(3'b010);
        repeat (20) @(negedge clk);
        measure(1, 1'b0, n);
        chk("R10 stored program unchanged", n, 65);
        set_ctrl(3'b000);

        // R10: disable rewinds the load pointer
        put_word(1, 16'h4030); put_word(1, 16'hA000);
        set_ctrl(3'b010);
        set_ctrl(3'b000);
        put_word(1, 16'h4050);
        set_ctrl(3'b010);
        repeat (20) @(negedge clk);
        measure(1, 1'b0, n);
        chk("R10 load pointer rewound", n, 81);
        set_ctrl(3'b000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule